// File: doc/BRIEF.md
# Accumulator Processor Core with Indexed Addressing

This block is a small multi-cycle processor for a 24-bit word machine with a 15-bit byte address space. Its registers are an accumulator, an index register, a linkage register, a program counter and a two-bit condition code. It runs word loads and stores, byte loads and stores, add, subtract, compare, and an index step that increments the index register and compares it with a limit. It also runs conditional and unconditional jumps, and a subroutine call and return that go through the linkage register.

All traffic uses one byte-wide synchronous memory port. The core presents an address in one cycle and takes the byte on `mem_rdata` in the next cycle. A write happens in the cycle in which `mem_we` is high. Each instruction is three bytes. The first byte is the opcode. The second byte holds the index flag in bit 7 and address bits 14:8. The third byte holds address bits 7:0. Words are stored most significant byte first.

A typical program copies a string with an indexed byte load, an indexed byte store, an index step and a jump-if-less that closes the loop. An opcode the core does not recognise stops it and raises `halted`.

Top module: `acc_core`

## Requirements
- R1: While `rst_n` is low, these outputs are zero: the program counter, the accumulator, the index register, the link register, `cc`, `halted` and `mem_we`. Execution starts at address 0.
- R2: An instruction is fetched as three bytes starting at the program counter, most significant byte first. The program counter then advances by 3 before the instruction executes.
- R3: The target address is the 15-bit address field. When the index flag is 1, the low 15 bits of X are added to it, modulo 32768.
- R4: LDA (00h), LDX (04h) and LDL (08h) load A, X or L with the big-endian word at the target address.
- R5: STA (0Ch) and STX (10h) write A or X as three bytes. The most significant byte goes to the target address.
- R6: ADD (18h) and SUB (1Ch) add the memory word to A, or subtract it from A, modulo 2^24.
- R7: COMP (28h) compares A with the memory word as signed 24-bit values. It sets `cc` to 01 for less, 00 for equal and 10 for greater.
- R8: TIX (2Ch) adds 1 to X, then compares the new X with the memory word as signed values and sets `cc` the same way as COMP.
- R9: JEQ (30h), JGT (34h) and JLT (38h) load the program counter with the target address only when `cc` is 00, 10 or 01 respectively. J (3Ch) always loads it.
- R10: JSUB (48h) writes the address of the next instruction into L and jumps to the target. RSUB (4Ch) loads the program counter from the low 15 bits of L.
- R11: LDCH (50h) replaces bits 7:0 of A with the byte at the target address and leaves bits 23:8 unchanged. STCH (54h) writes bits 7:0 of A to that one byte.
- R12: Any other opcode raises `halted`. After that the program counter and registers stay frozen and the core issues no memory write until reset.
- R13: Only COMP and TIX change `cc`. Reset sets it to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 15 | Byte address for the read or write |
| mem_rdata | input | 8 | Byte read from the address presented in the previous cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write enable for the current cycle |
| halted | output | 1 | Core has stopped on an unrecognised opcode |
| acc | output | 24 | Accumulator A |
| idx | output | 24 | Index register X |
| link | output | 24 | Linkage register L |
| pc | output | 15 | Program counter |
| cc | output | 2 | Condition code: 01 less, 00 equal, 10 greater |

## Verification
The assertions assume that `mem_rdata` always carries the byte addressed one cycle earlier. They also assume the program never overwrites an instruction it has not yet fetched, so the fetched word, the decoded opcode and the target address always agree. The bench memory model is a registered read with write-before-next-read behaviour. Every program is loaded while reset is held, keeps its code and data apart, and stays inside the modelled 4 KiB region. Each program ends on an unknown opcode, so every run stops at a known program counter value.

// File: rtl/acc_core.sv
module acc_core (
  input  logic        clk,
  input  logic        rst_n,
  output logic [14:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic        halted,
  output logic [23:0] acc,
  output logic [23:0] idx,
  output logic [23:0] link,
  output logic [14:0] pc,
  output logic [1:0]  cc
);

  localparam logic [7:0] OP_LDA  = 8'h00;
  localparam logic [7:0] OP_LDX  = 8'h04;
  localparam logic [7:0] OP_LDL  = 8'h08;
  localparam logic [7:0] OP_STA  = 8'h0C;
  localparam logic [7:0] OP_STX  = 8'h10;
  localparam logic [7:0] OP_ADD  = 8'h18;
  localparam logic [7:0] OP_SUB  = 8'h1C;
  localparam logic [7:0] OP_COMP = 8'h28;
  localparam logic [7:0] OP_TIX  = 8'h2C;
  localparam logic [7:0] OP_JEQ  = 8'h30;
  localparam logic [7:0] OP_JGT  = 8'h34;
  localparam logic [7:0] OP_JLT  = 8'h38;
  localparam logic [7:0] OP_J    = 8'h3C;
  localparam logic [7:0] OP_JSUB = 8'h48;
  localparam logic [7:0] OP_RSUB = 8'h4C;
  localparam logic [7:0] OP_LDCH = 8'h50;
  localparam logic [7:0] OP_STCH = 8'h54;

  localparam logic [1:0] CC_EQ = 2'b00;
  localparam logic [1:0] CC_LT = 2'b01;
  localparam logic [1:0] CC_GT = 2'b10;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_READ, S_EXEC, S_WRITE, S_HALT} state_t;

  state_t      st;
  logic [23:0] a_q, x_q, l_q, ir_q, dw_q;
  logic [14:0] pc_q, ta_q;
  logic [1:0]  cc_q, cnt_q;

  logic [7:0]  op;
  logic [14:0] ta_c;
  logic [23:0] x_inc, wsrc;
  logic        byte_op, op_read, op_write, op_branch;
  logic [1:0]  rd_last, wr_last;

  function automatic logic [1:0] cmp24(input logic [23:0] p, input logic [23:0] q);
    if ($signed(p) < $signed(q)) return CC_LT;
    else if (p == q)             return CC_EQ;
    else                         return CC_GT;
  endfunction

  assign op        = ir_q[23:16];
  assign ta_c      = ir_q[14:0] + (ir_q[15] ? x_q[14:0] : 15'd0);
  assign x_inc     = x_q + 24'd1;
  assign byte_op   = (op == OP_LDCH) || (op == OP_STCH);
  assign rd_last   = byte_op ? 2'd1 : 2'd3;
  assign wr_last   = byte_op ? 2'd0 : 2'd2;
  assign wsrc      = (op == OP_STX) ? x_q : a_q;
  assign op_read   = op inside {OP_LDA, OP_LDX, OP_LDL, OP_ADD, OP_SUB, OP_COMP, OP_TIX, OP_LDCH};
  assign op_write  = op inside {OP_STA, OP_STX, OP_STCH};
  assign op_branch = op inside {OP_JEQ, OP_JGT, OP_JLT, OP_J, OP_JSUB, OP_RSUB};

  assign mem_addr = ((st == S_FETCH) ? pc_q : ta_q) + {13'd0, cnt_q};
  assign mem_we   = (st == S_WRITE);
  assign halted   = (st == S_HALT);
  assign acc      = a_q;
  assign idx      = x_q;
  assign link     = l_q;
  assign pc       = pc_q;
  assign cc       = cc_q;

  always_comb begin
    case (cnt_q)
      2'd0:    mem_wdata = byte_op ? a_q[7:0] : wsrc[23:16];
      2'd1:    mem_wdata = wsrc[15:8];
      default: mem_wdata = wsrc[7:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_FETCH;
      a_q   <= '0;
      x_q   <= '0;
      l_q   <= '0;
      ir_q  <= '0;
      dw_q  <= '0;
      pc_q  <= '0;
      ta_q  <= '0;
      cc_q  <= CC_EQ;
      cnt_q <= '0;
    end else begin
      case (st)
        S_FETCH: begin
          if (cnt_q != 2'd0) ir_q <= {ir_q[15:0], mem_rdata};
          if (cnt_q == 2'd3) begin
            st    <= S_DECODE;
            cnt_q <= 2'd0;
            pc_q  <= pc_q + 15'd3;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        S_DECODE: begin
          ta_q  <= ta_c;
          cnt_q <= 2'd0;
          if (op_read)       st <= S_READ;
          else if (op_write) st <= S_WRITE;
          else if (op_branch) begin
            st <= S_FETCH;
            case (op)
              OP_JEQ:  if (cc_q == CC_EQ) pc_q <= ta_c;
              OP_JGT:  if (cc_q == CC_GT) pc_q <= ta_c;
              OP_JLT:  if (cc_q == CC_LT) pc_q <= ta_c;
              OP_J:    pc_q <= ta_c;
              OP_JSUB: begin
                l_q  <= {9'd0, pc_q};
                pc_q <= ta_c;
              end
              default: pc_q <= l_q[14:0];
            endcase
          end else begin
            st <= S_HALT;
          end
        end
        S_READ: begin
          if (cnt_q != 2'd0) dw_q <= {dw_q[15:0], mem_rdata};
          if (cnt_q == rd_last) begin
            st    <= S_EXEC;
            cnt_q <= 2'd0;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        S_EXEC: begin
          st <= S_FETCH;
          case (op)
            OP_LDA:  a_q <= dw_q;
            OP_LDX:  x_q <= dw_q;
            OP_LDL:  l_q <= dw_q;
            OP_ADD:  a_q <= a_q + dw_q;
            OP_SUB:  a_q <= a_q - dw_q;
            OP_COMP: cc_q <= cmp24(a_q, dw_q);
            OP_TIX: begin
              x_q  <= x_inc;
              cc_q <= cmp24(x_inc, dw_q);
            end
            OP_LDCH: a_q[7:0] <= dw_q[7:0];
            default: ;
          endcase
        end
        S_WRITE: begin
          if (cnt_q == wr_last) begin
            st    <= S_FETCH;
            cnt_q <= 2'd0;
          end else begin
            cnt_q <= cnt_q + 2'd1;
          end
        end
        default: st <= S_HALT;
      endcase
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DECODE) |-> (pc_q == $past(pc_q) + 15'd3)); // R2

  AST_TIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_EXEC && $past(op) == OP_TIX) |-> (x_q == $past(x_q) + 24'd1)); // R8

  AST_LINK_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_DECODE && $past(op) == OP_JSUB) |-> (l_q == {9'd0, $past(pc_q)} && pc_q == $past(ta_c))); // R10

  AST_CHAR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_EXEC && $past(op) == OP_LDCH) |-> (a_q[23:8] == $past(a_q[23:8]))); // R11

  AST_BAD_OP_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DECODE && !op_read && !op_write && !op_branch) |=> halted); // R12

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc_q) && !mem_we)); // R12

  AST_CC_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cc_q) |-> ($past(st) == S_EXEC && ($past(op) == OP_COMP || $past(op) == OP_TIX))); // R13

endmodule

// File: tb/sim_acc_core.sv
module sim_acc_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halted;
  logic [23:0] acc, idx, link;
  logic [14:0] pc;
  logic [1:0]  cc;

  logic [7:0]  mem [4096];
  logic        ld_en = 1'b0, ld_clr = 1'b0;
  logic [11:0] ld_a = '0;
  logic [7:0]  ld_d = '0;
  int          n_chk = 0, n_fail = 0, we_bad = 0;

  always #10 clk = ~clk;

  acc_core u0 (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted), .acc(acc),
    .idx(idx), .link(link), .pc(pc), .cc(cc)
  );

  always_ff @(posedge clk) begin
    if (ld_clr) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'h00;
    end else if (ld_en) begin
      mem[ld_a] <= ld_d;
    end else if (mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata;
    end
    mem_rdata <= mem[mem_addr[11:0]];
    if (halted && mem_we) we_bad <= we_bad + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    ld_clr = 1'b1;
    @(negedge clk);
    ld_clr = 1'b0;
  endtask

  task automatic put(input int a, input logic [7:0] d);
    ld_en = 1'b1;
    ld_a = a[11:0];
    ld_d = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic put3(input int a, input logic [23:0] w);
    put(a, w[23:16]);
    put(a + 1, w[15:8]);
    put(a + 2, w[7:0]);
  endtask

  task automatic run(input string tag);
    bit done = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (halted) begin
        done = 1;
        break;
      end
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL %s watchdog expired actual=running expected=halted", tag);
    end
  endtask

  localparam int NV = 9;
  localparam logic [81:0] VEC [NV] = '{
    {8'h18, 24'h000005, 24'h000007, 24'h00000C, 2'b00},
    {8'h18, 24'hFFFFFF, 24'h000002, 24'h000001, 2'b00},
    {8'h1C, 24'h000003, 24'h000005, 24'hFFFFFE, 2'b00},
    {8'h1C, 24'h800000, 24'h000001, 24'h7FFFFF, 2'b00},
    {8'h28, 24'h000003, 24'h000005, 24'h000003, 2'b01},
    {8'h28, 24'h000005, 24'h000005, 24'h000005, 2'b00},
    {8'h28, 24'hFFFFFF, 24'h000001, 24'hFFFFFF, 2'b01},
    {8'h28, 24'h000007, 24'h000002, 24'h000007, 2'b10},
    {8'h00, 24'h0ABCDE, 24'h123456, 24'h123456, 2'b00}
  };

  initial begin
    string s = "TEST STRING";

    for (int v = 0; v < NV; v++) begin
      hold_reset();
      put3(0, 24'h000100);
      put3(3, {VEC[v][81:74], 16'h0103});
      put3(6, 24'hFF0000);
      put3(12'h100, VEC[v][73:50]);
      put3(12'h103, VEC[v][49:26]);
      run("vector");
      chk($sformatf("R6/R7/R4 vector %0d acc", v), {8'd0, acc}, {8'd0, VEC[v][25:2]});
      chk($sformatf("R7/R13 vector %0d cc", v), {30'd0, cc}, {30'd0, VEC[v][1:0]});
      chk($sformatf("R2 vector %0d pc", v), {17'd0, pc}, 32'd9);
    end

    hold_reset();
    chk("R1 reset pc", {17'd0, pc}, 32'd0);
    chk("R1 reset acc", {8'd0, acc}, 32'd0);
    chk("R1 reset flags", {28'd0, halted, mem_we, cc}, 32'd0);
    put3(0, 24'h040200);
    put3(3, 24'h508300);
    put3(6, 24'h548340);
    put3(9, 24'h2C0203);
    put3(12, 24'h380003);
    put3(15, 24'h0C0360);
    put3(18, 24'h480030);
    put3(21, 24'hFF0000);
    put3(12'h030, 24'h180206);
    put3(12'h033, 24'h4C0000);
    put3(12'h203, 24'h00000B);
    put3(12'h206, 24'h000001);
    for (int i = 0; i < 11; i++) put(12'h300 + i, s[i]);
    put(12'h34B, 8'hAA);
    run("copy");
    for (int i = 0; i < 11; i++)
      chk($sformatf("R3/R11 copied byte %0d", i), {24'd0, mem[12'h340 + i]}, {24'd0, s[i]});
    chk("R11 byte past copy untouched", {24'd0, mem[12'h34B]}, 32'h000000AA);
    chk("R8 index after loop", {8'd0, idx}, 32'd11);
    chk("R8 cc after final step", {30'd0, cc}, 32'd0);
    chk("R5 store word", {8'd0, mem[12'h360], mem[12'h361], mem[12'h362]}, 32'h00000047);
    chk("R10 link", {8'd0, link}, 32'd21);
    chk("R10 acc after subroutine", {8'd0, acc}, 32'h00000048);
    chk("R10 pc after return", {17'd0, pc}, 32'd24);

    hold_reset();
    chk("R1 reset clears link", {8'd0, link}, 32'd0);
    chk("R1 reset clears idx", {8'd0, idx}, 32'd0);
    put3(0, 24'h000100);
    put3(3, 24'h500103);
    put3(6, 24'h040104);
    put3(9, 24'h100110);
    put3(12, 24'h300012);
    put3(15, 24'hFF0000);
    put3(18, 24'h280107);
    put3(21, 24'h30001E);
    put3(24, 24'h340021);
    put3(27, 24'hFF0000);
    put3(30, 24'hFF0000);
    put3(33, 24'hFF0000);
    put3(12'h100, 24'h123400);
    put(12'h103, 8'h5A);
    put3(12'h104, 24'h000102);
    run("branch");
    chk("R11 LDCH keeps upper A", {8'd0, acc}, 32'h0012345A);
    chk("R4 LDX", {8'd0, idx}, 32'h00000102);
    chk("R5 STX bytes", {8'd0, mem[12'h110], mem[12'h111], mem[12'h112]}, 32'h00000102);
    chk("R9 jump path pc", {17'd0, pc}, 32'd36);
    chk("R7/R13 cc greater held", {30'd0, cc}, 32'd2);

    hold_reset();
    put3(0, 24'hFF0000);
    put(12'h010, 8'h55);
    run("halt");
    chk("R12 halted", {31'd0, halted}, 32'd1);
    chk("R12 pc at halt", {17'd0, pc}, 32'd3);
    repeat (20) @(negedge clk);
    chk("R12 pc frozen", {17'd0, pc}, 32'd3);
    chk("R12 still halted", {31'd0, halted}, 32'd1);
    chk("R12 no write while halted", we_bad, 32'd0);
    chk("R12 acc untouched", {8'd0, acc}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule